// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single line and presents each received word to a processor. It runs from the core clock. A one-cycle strobe, `tick_i`, arrives sixteen times per bit period. When reception is enabled, the block waits for the line to fall. It confirms a start bit at the middle of the bit, then samples each later bit at its centre. The frame format is chosen by static control inputs: 7 or 8 data bits, optional even or odd parity, and LSB-first or MSB-first order.

A completed frame is copied into a holding register and a data-full flag is raised. Sticky flags record parity mismatch, a low stop bit and overrun. An overrun is a completed frame that found the holding register still unread. A read strobe from the processor empties the holding register. A separate clear strobe resets the three error flags. The interrupt line follows the full flag, gated by an enable.

Top module: `srx_unit`

## Requirements
- R1: While `rx_en_i` is 0 the receiver ignores the line. A complete frame sent in that state changes no output.
- R2: A falling edge starts a frame only if the line is still low at the 8th tick after detection. A shorter low pulse leaves every output unchanged.
- R3: Each bit is sampled once every 16 ticks at its centre. With `tick_i` held high, `rdata_o` and `full_o` update at clock edge 28+16·n after the edge where the line fell. Here n counts the data bits plus the parity bit.
- R4: With `len8_i`=0 a frame carries 7 data bits and `rdata_o[7]` reads 0, in either bit order.
- R5: With `msb_first_i`=0 the first data bit after the start bit lands in `rdata_o[0]`. With `msb_first_i`=1 it lands in the top data bit: bit 7, or bit 6 in 7-bit mode.
- R6: With `par_en_i`=1 one parity bit follows the data. With `par_odd_i`=0 the data and parity bits together hold an even number of ones; with 1, an odd number. A mismatch sets `perr_o`.
- R7: A stop bit sampled low sets `ferr_o`. The received word is still stored.
- R8: A frame that completes while `full_o` is 1 and `rd_i` is 0 sets `oerr_o`. `rdata_o`, `full_o`, `perr_o` and `ferr_o` keep their values.
- R9: A one-cycle `rd_i` pulse clears `full_o` at the next edge. A frame completing in the same cycle is stored and leaves `full_o` at 1.
- R10: Error flags are sticky. A one-cycle `err_clr_i` pulse clears all three at the next edge and leaves `full_o` and `rdata_o` unchanged.
- R11: `irq_o` equals `full_o` AND `irq_en_i`.
- R12: After reset, `rdata_o` is 0 and `full_o`, `perr_o`, `oerr_o`, `ferr_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample strobe, 16 per bit period |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| msb_first_i | input | 1 | 1: MSB first on the line |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Processor read of the data register |
| err_clr_i | input | 1 | Clear all error flags |
| rdata_o | output | 8 | Received data register |
| full_o | output | 1 | Data register holds an unread word |
| perr_o | output | 1 | Parity error flag |
| oerr_o | output | 1 | Overrun error flag |
| ferr_o | output | 1 | Framing error flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a framing error: the low stop bit makes the idle receiver detect a false start right after the frame ends, and the mid-bit check must then reject it. The bench sends a frame with a low stop bit and restores the idle level only after one bit period, so exactly this restart-then-reject sequence happens. The second is overrun: the bench sends two frames back to back without a read. It checks that the first word survives, then shows through the read and clear strobes that the flags behave normally afterwards.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [SRX_DW-1:0] word;
    logic              perr;
    logic              ferr;
  } rx_result_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       en_i,
  input  logic       len8_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       msb_first_i,
  output logic       done_o,
  output rx_result_t res_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(SRX_DW);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  os_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SRX_DW-1:0] shreg_q;
  logic              par_acc_q, perr_q, ferr_q, done_q;
  logic [IDX_W-1:0]  last_idx, bit_pos;
  logic              at_mid, at_end;

  assign last_idx = len8_i ? IDX_W'(SRX_DW-1) : IDX_W'(SRX_DW-2);
  assign bit_pos  = msb_first_i ? (last_idx - idx_q) : idx_q;
  assign at_mid   = (os_q == MID_CNT);
  assign at_end   = (os_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      os_q      <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      par_acc_q <= 1'b0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rx_i) begin
            state_q <= ST_START;
            os_q    <= '0;
          end
          ST_START: begin
            if (at_mid) begin
              if (!rx_i) begin
                state_q   <= ST_DATA;
                os_q      <= '0;
                idx_q     <= '0;
                shreg_q   <= '0;
                perr_q    <= 1'b0;
                par_acc_q <= par_odd_i;
              end else begin
                state_q <= ST_IDLE;  // glitch
              end
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_end) begin
              os_q             <= '0;
              shreg_q[bit_pos] <= rx_i;
              par_acc_q        <= par_acc_q ^ rx_i;
              if (idx_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_end) begin
              os_q    <= '0;
              perr_q  <= par_acc_q ^ rx_i;
              state_q <= ST_STOP;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_end) begin
              os_q    <= '0;
              ferr_q  <= ~rx_i;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o     = done_q;
  assign res_o.word = shreg_q;
  assign res_o.perr = perr_q;
  assign res_o.ferr = ferr_q;

  // R1
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_IDLE);

  // R2
  glitch_rej_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i && state_q == ST_START && at_mid && rx_i |=> state_q == ST_IDLE);
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_result_t        res_i,
  input  logic              rd_i,
  input  logic              clr_i,
  input  logic              irq_en_i,
  output logic [SRX_DW-1:0] rdata_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              oerr_o,
  output logic              ferr_o,
  output logic              irq_o
);
  logic [SRX_DW-1:0] rdata_q;
  logic              full_q, perr_q, oerr_q, ferr_q;
  logic              accept, blocked;

  assign accept  = done_i && (!full_q || rd_i);
  assign blocked = done_i && full_q && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      full_q  <= 1'b0;
      perr_q  <= 1'b0;
      oerr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      if (accept) rdata_q <= res_i.word;
      full_q <= accept | (full_q & ~rd_i);
      perr_q <= (perr_q & ~clr_i) | (accept & res_i.perr);
      ferr_q <= (ferr_q & ~clr_i) | (accept & res_i.ferr);
      oerr_q <= (oerr_q & ~clr_i) | blocked;
    end
  end

  assign rdata_o = rdata_q;
  assign full_o  = full_q;
  assign perr_o  = perr_q;
  assign oerr_o  = oerr_q;
  assign ferr_o  = ferr_q;
  assign irq_o   = full_q & irq_en_i;

  // R3
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !full_o |=> full_o);

  // R8
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && full_o && !rd_i |=> full_o && oerr_o && $stable(rdata_o));

  // R9
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !full_o);

  // R10
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !done_i |=> !perr_o && !oerr_o && !ferr_o && $stable(rdata_o));
endmodule

// File: rtl/srx_unit.sv
module srx_unit
  import srx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       rx_en_i,
  input  logic       len8_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       msb_first_i,
  input  logic       irq_en_i,
  input  logic       rd_i,
  input  logic       err_clr_i,
  output logic [7:0] rdata_o,
  output logic       full_o,
  output logic       perr_o,
  output logic       oerr_o,
  output logic       ferr_o,
  output logic       irq_o
);
  logic       rx_s;
  logic       done;
  rx_result_t res;

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  srx_frame #(.OS_RATE(OS_RATE)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .rx_i       (rx_s),
    .en_i       (rx_en_i),
    .len8_i     (len8_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .msb_first_i(msb_first_i),
    .done_o     (done),
    .res_o      (res)
  );

  srx_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .res_i   (res),
    .rd_i    (rd_i),
    .clr_i   (err_clr_i),
    .irq_en_i(irq_en_i),
    .rdata_o (rdata_o),
    .full_o  (full_o),
    .perr_o  (perr_o),
    .oerr_o  (oerr_o),
    .ferr_o  (ferr_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/srx_unit_bench.sv
module srx_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic rx = 1'b1;
  logic rx_en = 1'b1, len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, msb_first = 1'b0;
  logic irq_en = 1'b1, rd = 1'b0, err_clr = 1'b0;
  logic [7:0] rdata;
  logic full, perr, oerr, ferr, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  logic [7:0] m_data = '0;
  bit m_full = 0, m_perr = 0, m_oerr = 0, m_ferr = 0;
  int         q_due[$];
  logic [7:0] q_dat[$];
  bit         q_pe[$];
  bit         q_fe[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  srx_unit u_srx_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx), .rx_en_i(rx_en),
    .len8_i(len8), .par_en_i(par_en), .par_odd_i(par_odd), .msb_first_i(msb_first),
    .irq_en_i(irq_en), .rd_i(rd), .err_clr_i(err_clr),
    .rdata_o(rdata), .full_o(full), .perr_o(perr), .oerr_o(oerr), .ferr_o(ferr), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h @cyc %0d", req, act, exp, cyc);
    end
  endtask

  // model update on every edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_data = '0; m_full = 0; m_perr = 0; m_oerr = 0; m_ferr = 0;
    end else begin
      if (err_clr) begin m_perr = 0; m_oerr = 0; m_ferr = 0; end
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        logic [7:0] d; bit pe, fe;
        void'(q_due.pop_front());
        d = q_dat.pop_front(); pe = q_pe.pop_front(); fe = q_fe.pop_front();
        if (m_full && !rd) m_oerr = 1;
        else begin
          m_full = 1; m_data = d;
          if (pe) m_perr = 1;
          if (fe) m_ferr = 1;
        end
      end else if (rd) begin
        m_full = 0;
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rdata === m_data, "R3 rdata", rdata, m_data);
      chk(full === m_full, "R3/R9 full", full, m_full);
      chk(perr === m_perr, "R6 perr", perr, m_perr);
      chk(oerr === m_oerr, "R8 oerr", oerr, m_oerr);
      chk(ferr === m_ferr, "R7 ferr", ferr, m_ferr);
      chk(irq === (m_full & irq_en), "R11 irq", irq, m_full & irq_en);
    end
  end

  task automatic send_frame(input logic [7:0] val, input bit l8, input bit msb,
                            input bit pen, input bit podd, input bit bad_par, input bit stop_v);
    int nb, n;
    bit ones;
    nb = l8 ? 8 : 7;
    n  = nb + (pen ? 1 : 0);
    @(negedge clk);
    len8 = l8; msb_first = msb; par_en = pen; par_odd = podd;
    repeat (2) @(negedge clk);
    rx = 1'b0;
    if (rx_en) begin
      q_due.push_back(cyc + 28 + 16*n);
      q_dat.push_back(l8 ? val : (val & 8'h7F));
      q_pe.push_back(pen & bad_par);
      q_fe.push_back(!stop_v);
    end
    repeat (16) @(negedge clk);
    ones = 0;
    for (int j = 0; j < nb; j++) begin
      rx = msb ? val[nb-1-j] : val[j];
      ones = ones ^ val[j];
      repeat (16) @(negedge clk);
    end
    if (pen) begin
      rx = (podd ? ~ones : ones) ^ bad_par;
      repeat (16) @(negedge clk);
    end
    rx = stop_v;
    repeat (16) @(negedge clk);
    rx = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(rdata == 8'h00 && !full && !perr && !oerr && !ferr && !irq, "R12 reset", {full, perr, oerr, ferr, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R5 lsb first 8 bit
    send_frame(8'hA5, 1, 0, 0, 0, 0, 1);
    chk(rdata == 8'hA5 && full, "R3 lsb frame", rdata, 8'hA5);
    pulse_rd();
    chk(!full, "R9 read clears", full, 0);

    // R5 msb first
    send_frame(8'h3C, 1, 1, 0, 0, 0, 1);
    chk(rdata == 8'h3C, "R5 msb order", rdata, 8'h3C);
    pulse_rd();
    send_frame(8'h01, 1, 1, 0, 0, 0, 1);
    chk(rdata == 8'h01, "R5 msb single bit", rdata, 8'h01);
    pulse_rd();

    // R4 seven-bit, both orders
    send_frame(8'hD3, 0, 0, 0, 0, 0, 1);
    chk(rdata == 8'h53, "R4 7bit lsb", rdata, 8'h53);
    pulse_rd();
    send_frame(8'hF1, 0, 1, 0, 0, 0, 1);
    chk(rdata == 8'h71, "R4 7bit msb", rdata, 8'h71);
    pulse_rd();

    // R6 parity good even / odd, then bad
    send_frame(8'h96, 1, 0, 1, 0, 0, 1);
    chk(!perr && rdata == 8'h96, "R6 even ok", perr, 0);
    pulse_rd();
    send_frame(8'h07, 1, 0, 1, 1, 0, 1);
    chk(!perr, "R6 odd ok", perr, 0);
    pulse_rd();
    send_frame(8'h5A, 0, 1, 1, 1, 1, 1);
    chk(perr, "R6 bad parity", perr, 1);
    pulse_rd();
    chk(perr, "R10 sticky perr", perr, 1);
    pulse_clr();
    chk(!perr, "R10 clear", perr, 0);

    // R7 framing error (restart then reject on stuck-low stop)
    send_frame(8'hC3, 1, 0, 0, 0, 0, 0);
    chk(ferr && full && rdata == 8'hC3, "R7 low stop", ferr, 1);
    pulse_rd();
    pulse_clr();

    // R8 overrun
    send_frame(8'h11, 1, 0, 0, 0, 0, 1);
    send_frame(8'h22, 1, 0, 0, 0, 0, 0);
    chk(oerr && rdata == 8'h11 && full && !ferr, "R8 overrun keeps", rdata, 8'h11);
    pulse_clr();
    chk(!oerr && full && rdata == 8'h11, "R10 clear keeps data", {oerr, full}, 1);

    // R11 irq gating
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    chk(!irq, "R11 gated", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq, "R11 raised", irq, 1);
    pulse_rd();

    // R2 glitch rejection
    @(negedge clk); rx = 1'b0;
    repeat (4) @(negedge clk); rx = 1'b1;
    repeat (60) @(negedge clk);
    chk(!full && rdata == 8'h11, "R2 glitch ignored", full, 0);

    // R1 disabled receiver
    @(negedge clk); rx_en = 1'b0;
    send_frame(8'hEE, 1, 0, 0, 0, 0, 1);
    chk(!full && rdata == 8'h11, "R1 disabled", rdata, 8'h11);
    rx_en = 1'b1;
    send_frame(8'h6B, 1, 1, 1, 0, 0, 1);
    chk(full && rdata == 8'h6B && !perr, "R1 reenabled", rdata, 8'h6B);
    pulse_rd();

    repeat (10) @(negedge clk);
    summary();
  end
endmodule